// File: doc/BRIEF.md
# Tap-Clocked Watchdog Timer

This block is a software watchdog that sits at the end of a shared timer divider chain. It counts rising edges of one selected periodic tap from that chain through a short parameterised stage counter, which is three binary stages by default. When the stages wrap past their all-ones value, the block drives a system reset pulse with a fixed length. At the same moment it clears the stages. Software stops this from happening by writing a clear command to a dedicated bus address. The command is a write with data bit 0 at zero. Writes with bit 0 at one, and writes to any other address, are ignored.

A clear only empties the watchdog stages. The lower divider chain that produces the tap keeps running. The time from a clear to the timeout is therefore between seven and eight tap periods with the default three stages. The watchdog counts in every operating mode except stop. A stop request clears the stages and blocks tap edges for as long as it is held. Two static straps change this behaviour. One turns the watchdog off entirely. The other makes the block ignore stop requests, so a stop acts like halt and counting goes on. A change of rate select in the shared chain changes the tap period, and the watchdog counting rate follows it.

Top module: `tap_watchdog`

## Requirements
- R1: After reset the stage count is zero and `wdt_rst_o` is low.
- R2: Each low-to-high transition of `tap_i` advances the stages by one. Exactly 2^STAGES rising edges with no clear in between start a reset pulse. 2^STAGES-1 edges start none.
- R3: A reset pulse holds `wdt_rst_o` high for exactly RST_PULSE bus cycles. The stages restart from zero, so the next pulse again needs 2^STAGES further edges.
- R4: A write with `wr_en_i`=1, `wr_addr_i`=CLR_ADDR and `wr_data_i` bit 0 equal to 0 resets the stages to zero. After such a write, 2^STAGES new edges are needed to reach a timeout.
- R5: A write to CLR_ADDR with `wr_data_i` bit 0 equal to 1 leaves the stage count unchanged.
- R6: A write to any address other than CLR_ADDR leaves the stage count unchanged, whatever the data.
- R7: With `stop_i`=1 and `stop_halt_strap_i`=0, the stages are cleared and tap edges are not counted until `stop_i` returns to 0.
- R8: With `stop_halt_strap_i`=1, `stop_i` has no effect and counting continues.
- R9: With `dis_strap_i`=1, no reset pulse is produced for any number of tap edges, and `wdt_rst_o` stays low.
- R10: A tap that stays high for many cycles counts as one edge only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tap_i | input | 1 | Selected periodic tap from the shared divider chain |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW | Register write address |
| wr_data_i | input | DW | Register write data; bit 0 = 0 is the clear command |
| stop_i | input | 1 | Stop mode request |
| dis_strap_i | input | 1 | Strap: 1 disables the watchdog |
| stop_halt_strap_i | input | 1 | Strap: 1 makes stop behave as halt for the watchdog |
| wdt_rst_o | output | 1 | System reset request pulse |

## Verification
The bench builds the block with TAP_SYNC=2, RST_PULSE=5, STAGES=3 and a clear address of 10'h2A4. This keeps the synchroniser path and a pulse length that differs from the default in play. The bench drives the tap directly as a fast square wave rather than from a long divider chain. A full timeout therefore takes only eight tap edges, which makes the seven-versus-eight edge boundary, the clear points and the stop windows cheap to reach. The 5-cycle pulse width is measured by a monitor that counts high cycles of the reset output.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   // Decode of the software clear command: matching address, bit 0 low.
   function automatic logic is_clear_cmd(input logic en, input logic addr_hit, input logic bit0);
      return en & addr_hit & ~bit0;
   endfunction

   // Width needed to hold a count value up to n.
   function automatic int cnt_width(input int n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/wdt_tap_edge.sv
module wdt_tap_edge #(
   parameter int SYNC = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tap_i,
   output logic rise_o
);

   logic tap_s;
   logic tap_prev;

   generate
      if (SYNC < 0) begin : g_bad
         $error("wdt_tap_edge: SYNC must not be negative");
      end
      if (SYNC == 0) begin : g_direct
         assign tap_s = tap_i;
      end else begin : g_sync
         logic [SYNC:0] chain;
         assign chain[0] = tap_i;
         for (genvar k = 0; k < SYNC; k++) begin : g_ff
            always_ff @(posedge clk_i) begin
               if (!rst_ni) chain[k+1] <= 1'b0;
               else         chain[k+1] <= chain[k];
            end
         end
         assign tap_s = chain[SYNC];
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (!rst_ni) tap_prev <= 1'b0;
      else         tap_prev <= tap_s;
   end

   assign rise_o = tap_s & ~tap_prev;

endmodule

// File: rtl/wdt_stage_chain.sv
module wdt_stage_chain #(
   parameter int STAGES = 3
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clr_i,
   input  logic              step_i,
   output logic [STAGES-1:0] cnt_o,
   output logic              ovf_o
);

   logic [STAGES:0]   carry;
   logic [STAGES-1:0] q;

   generate
      if (STAGES < 1) begin : g_bad
         $error("wdt_stage_chain: STAGES must be at least 1");
      end
   endgenerate

   assign carry[0] = step_i;

   generate
      for (genvar k = 0; k < STAGES; k++) begin : g_stage
         always_ff @(posedge clk_i) begin
            if (!rst_ni)       q[k] <= 1'b0;
            else if (clr_i)    q[k] <= 1'b0;
            else if (carry[k]) q[k] <= ~q[k];
         end
         assign carry[k+1] = carry[k] & q[k];
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (!rst_ni) ovf_o <= 1'b0;
      else         ovf_o <= carry[STAGES] & ~clr_i;
   end

   assign cnt_o = q;

   // R2: a wrap leaves every stage at zero
   wrap_to_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_o |-> (q == '0));

endmodule

// File: rtl/wdt_rst_stretch.sv
module wdt_rst_stretch #(
   parameter int RST_PULSE = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic kill_i,
   input  logic start_i,
   output logic pulse_o
);

   localparam int CW = wdt_pkg::cnt_width(RST_PULSE);
   localparam logic [CW-1:0] LOAD = CW'(RST_PULSE);

   logic [CW-1:0] left;

   generate
      if (RST_PULSE < 1) begin : g_bad
         $error("wdt_rst_stretch: RST_PULSE must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (!rst_ni)           left <= '0;
      else if (kill_i)       left <= '0;
      else if (start_i)      left <= LOAD;
      else if (left != '0)   left <= left - 1'b1;
   end

   assign pulse_o = (left != '0);

   // R3: a start request always produces a high output next cycle
   start_drives_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && !kill_i) |=> pulse_o);

endmodule

// File: rtl/tap_watchdog.sv
module tap_watchdog #(
   parameter int              STAGES    = 3,
   parameter int              RST_PULSE = 4,
   parameter int              TAP_SYNC  = 2,
   parameter int              AW        = 10,
   parameter int              DW        = 8,
   parameter logic [AW-1:0]   CLR_ADDR  = 10'h3C8
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          tap_i,
   input  logic          wr_en_i,
   input  logic [AW-1:0] wr_addr_i,
   input  logic [DW-1:0] wr_data_i,
   input  logic          stop_i,
   input  logic          dis_strap_i,
   input  logic          stop_halt_strap_i,
   output logic          wdt_rst_o
);

   logic              tap_rise;
   logic              active;
   logic              stop_eff;
   logic              sw_clear;
   logic              stage_clr;
   logic              step;
   logic              ovf;
   logic [STAGES-1:0] stage_cnt;
   logic              unused_bits;

   generate
      if (AW < 1 || DW < 1) begin : g_bad
         $error("tap_watchdog: AW and DW must be at least 1");
      end
   endgenerate

   assign unused_bits = ^{wr_data_i, stage_cnt};

   assign active    = ~dis_strap_i;
   assign stop_eff  = stop_i & ~stop_halt_strap_i;
   assign sw_clear  = wdt_pkg::is_clear_cmd(wr_en_i, wr_addr_i == CLR_ADDR, wr_data_i[0]);
   assign stage_clr = ~active | stop_eff | sw_clear;
   assign step      = tap_rise & active & ~stop_eff;

   wdt_tap_edge #(.SYNC(TAP_SYNC)) u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tap_i  (tap_i),
      .rise_o (tap_rise)
   );

   wdt_stage_chain #(.STAGES(STAGES)) u_chain (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (stage_clr),
      .step_i (step),
      .cnt_o  (stage_cnt),
      .ovf_o  (ovf)
   );

   wdt_rst_stretch #(.RST_PULSE(RST_PULSE)) u_stretch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .kill_i  (~active),
      .start_i (ovf),
      .pulse_o (wdt_rst_o)
   );

   // R4
   clr_blocks_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sw_clear |=> !ovf);

   // R7
   stop_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stop_eff |=> !ovf);

   // R9
   dis_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dis_strap_i |=> !wdt_rst_o);

   // R1
   reset_quiet_chk: assert property (@(posedge clk_i)
      !rst_ni |=> !wdt_rst_o);

endmodule

// File: tb/sim_tap_watchdog.sv
module sim_tap_watchdog;

   localparam int            STAGES = 3;
   localparam int            PULSE  = 5;
   localparam int            AW     = 10;
   localparam int            DW     = 8;
   localparam logic [AW-1:0] CADDR  = 10'h2A4;
   localparam int            FULL   = 2 ** STAGES;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tap = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          stop = 1'b0;
   logic          dis = 1'b0;
   logic          halt_strap = 1'b0;
   logic          rst_out;

   int checks = 0;
   int errors = 0;
   int starts = 0;
   int run_len = 0;
   int last_width = 0;
   logic prev_rst = 1'b0;

   always #10 clk = ~clk;

   tap_watchdog #(
      .STAGES(STAGES), .RST_PULSE(PULSE), .TAP_SYNC(2),
      .AW(AW), .DW(DW), .CLR_ADDR(CADDR)
   ) u0 (
      .clk_i(clk), .rst_ni(rst_n), .tap_i(tap), .wr_en_i(wr_en),
      .wr_addr_i(wr_addr), .wr_data_i(wr_data), .stop_i(stop),
      .dis_strap_i(dis), .stop_halt_strap_i(halt_strap), .wdt_rst_o(rst_out)
   );

   // Pulse monitor, sampled away from the active edge.
   always @(negedge clk) begin
      if (rst_out && !prev_rst) begin
         starts  <= starts + 1;
         run_len <= 1;
      end else if (rst_out) begin
         run_len <= run_len + 1;
      end else if (prev_rst) begin
         last_width <= run_len;
      end
      prev_rst <= rst_out;
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; tap = 1'b0; wr_en = 1'b0; stop = 1'b0;
      dis = 1'b0; halt_strap = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic pulses(input int n);
      for (int i = 0; i < n; i++) begin
         tap = 1'b1; repeat (4) @(negedge clk);
         tap = 1'b0; repeat (4) @(negedge clk);
      end
      repeat (12) @(negedge clk);
   endtask

   task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      int s0;
      do_reset();
      s0 = starts;
      check("R1 output low after reset", int'(rst_out), 0);
      pulses(FULL - 1);
      check("R1 count starts at zero", starts - s0, 0);
   endtask

   task automatic t_timeout();
      int s0;
      do_reset();
      s0 = starts;
      pulses(FULL - 1);
      check("R2 one edge short", starts - s0, 0);
      pulses(1);
      check("R2 full count fires", starts - s0, 1);
      check("R3 pulse width", last_width, PULSE);
      pulses(FULL - 1);
      check("R3 stages restart", starts - s0, 1);
      pulses(1);
      check("R3 second timeout", starts - s0, 2);
   endtask

   task automatic t_clear();
      int s0;
      do_reset();
      s0 = starts;
      pulses(5);
      bus_write(CADDR, 8'hFE);
      pulses(FULL - 1);
      check("R4 clear restarts count", starts - s0, 0);
      pulses(1);
      check("R4 fires after full count", starts - s0, 1);
   endtask

   task automatic t_clear_ignored();
      int s0;
      do_reset();
      s0 = starts;
      pulses(5);
      bus_write(CADDR, 8'h01);
      pulses(FULL - 6);
      check("R5 bit0=1 no effect, short", starts - s0, 0);
      pulses(1);
      check("R5 bit0=1 no effect", starts - s0, 1);
   endtask

   task automatic t_wrong_addr();
      int s0;
      do_reset();
      s0 = starts;
      pulses(5);
      bus_write(CADDR + 1'b1, 8'h00);
      bus_write(CADDR ^ 10'h200, 8'h00);
      pulses(FULL - 5);
      check("R6 other address no effect", starts - s0, 1);
   endtask

   task automatic t_stop();
      int s0;
      do_reset();
      s0 = starts;
      pulses(5);
      stop = 1'b1;
      pulses(FULL + 2);
      check("R7 no timeout in stop", starts - s0, 0);
      stop = 1'b0;
      pulses(FULL - 1);
      check("R7 stop cleared stages", starts - s0, 0);
      pulses(1);
      check("R7 counts after stop", starts - s0, 1);
   endtask

   task automatic t_stop_halt();
      int s0;
      do_reset();
      halt_strap = 1'b1;
      s0 = starts;
      pulses(5);
      stop = 1'b1;
      pulses(FULL - 5);
      check("R8 stop as halt keeps counting", starts - s0, 1);
      stop = 1'b0;
   endtask

   task automatic t_disable();
      int s0;
      do_reset();
      dis = 1'b1;
      s0 = starts;
      pulses(3 * FULL);
      check("R9 disabled never fires", starts - s0, 0);
      check("R9 output low", int'(rst_out), 0);
   endtask

   task automatic t_level();
      int s0;
      do_reset();
      s0 = starts;
      tap = 1'b1; repeat (60) @(negedge clk);
      tap = 1'b0; repeat (4) @(negedge clk);
      pulses(FULL - 2);
      check("R10 long high counts once", starts - s0, 0);
      pulses(1);
      check("R10 fires on full count", starts - s0, 1);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_timeout();
      t_clear();
      t_clear_ignored();
      t_wrong_addr();
      t_stop();
      t_stop_halt();
      t_disable();
      t_level();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule